// File: doc/BRIEF.md
# Clock Output Gate Controller

This block hands out seven gated copies of a reference clock, each as a true/complement pair. Three controls decide whether a given pair runs. The first is an active-low enable pin for that output. The second is an enable bit held in a small configuration register. The third is a global power input, which is high for run and low for power-down. A pair runs only when all three allow it. Otherwise it sits with both legs low. Every start and stop is timed against the reference clock, so a gated waveform only ever contains whole pulses.

The power input has two roles. Its first rising edge after reset fires a one-cycle strobe that tells the surrounding chip to capture its strap inputs, and a flag then records that this has been done. Every later low level puts the outputs into power-down, and every later rising edge starts a wake-up. During a wake-up the outputs stay stopped for a parameterized number of cycles of a separate free-running clock, which stands in for the settling time. The enable pins and the power state are brought into the reference-clock domain through two-flop synchronizers. The block has no streaming data path, so it has no valid/ready interface: all of its pins are plain control and status levels.

Top module: `clk_fanout_gate`

## Requirements
- R1: While reset is asserted, and after reset until the power input first rises, every output pair is low/low and `strap_strobe`/`strap_done` are 0. Reset sets all configuration enable bits to 1.
- R2: Output i runs when three conditions hold: the power sequence is ready, configuration bit i is 1, and `oe_n[i]` is 0. Running means `clk_out_p[i]` is high in each reference-clock high phase and `clk_out_n[i]` is high in each low phase.
- R3: While `oe_n[i]` is 1, pair i is low/low, with both legs 0 in both clock phases.
- R4: A configuration write (`cfg_we` high at a rising edge of `ref_clk`) loads `cfg_wdata`, where bit i controls output i. A 0 in bit i forces pair i low/low whatever `oe_n[i]` is.
- R5: When the power input goes low, every pair becomes low/low within 3 `aux_clk` cycles plus 4 `ref_clk` cycles, and stays low/low while the input stays low.
- R6: The first rising edge of the power input after reset gives exactly one `aux_clk` cycle of `strap_strobe`, after which `strap_done` stays 1. Later rising edges give no strobe.
- R7: After each rising edge of the power input, outputs stay stopped for at least WAKE_CYCLES `aux_clk` cycles. They run within WAKE_CYCLES + 6 `aux_clk` cycles.
- R8: After `oe_n[i]` changes, the first affected high phase of `clk_out_p[i]` begins at the third rising edge of `ref_clk`. After a configuration write, it begins at the first rising edge that follows the edge that accepted the write.
- R9: `clk_out_p` changes only between whole high phases and `clk_out_n` only between whole low phases, so there are never any runt pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock that is gated to the outputs |
| aux_clk | input | 1 | Free-running clock used to time the wake-up |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_req | input | 1 | Power input: high = run, low = power-down; first rise triggers the strap strobe |
| oe_n | input | NUM_OUT | Per-output active-low enable pins |
| cfg_we | input | 1 | Configuration register write strobe (ref_clk domain) |
| cfg_wdata | input | NUM_OUT | Configuration enable bits, bit i for output i |
| clk_out_p | output | NUM_OUT | True clock outputs |
| clk_out_n | output | NUM_OUT | Complement clock outputs |
| strap_strobe | output | 1 | One-cycle strap-capture pulse (aux_clk domain) |
| strap_done | output | 1 | Set once the strap strobe has been issued |

## Verification
A gate flop for one lane that holds the wrong value makes that pair run or stop against what its three controls ask for, and this is visible within one reference cycle. The sweep over every pin pattern and many register patterns finds it in the very next sampled cycle. A wrong synchronizer depth or wrong edge choice shifts the start or stop edge by a cycle, or cuts a pulse short, and the exact edge-count checks and the mid-phase runt monitor catch that on the first transition. A wake-up counter or strap flag in the wrong state shows up either as outputs starting before the settle window ends, or as a second strobe on a later power-up.

// File: rtl/gate_pkg.sv
package gate_pkg;
  localparam int unsigned DEF_NUM_OUT     = 7;
  localparam int unsigned DEF_WAKE_CYCLES = 30000; // 300 us at a 100 MHz aux clock
  localparam int unsigned DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/cdc_sync.sv
module cdc_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic        RST_V  = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{{W{RST_V}}}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pwr_sequencer.sv
module pwr_sequencer #(
  parameter int unsigned WAKE_CYCLES = gate_pkg::DEF_WAKE_CYCLES,
  parameter int unsigned SYNC_STAGES = gate_pkg::DEF_SYNC_STAGES
) (
  input  logic aux_clk,
  input  logic rst_n,
  input  logic pwr_req,
  output logic ready,
  output logic strap_strobe,
  output logic strap_done
);
  localparam int unsigned CW = $clog2(WAKE_CYCLES + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(WAKE_CYCLES);

  logic          pwr_s;
  logic          pwr_d;
  logic          rise;
  logic [CW-1:0] cnt;

  cdc_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_V(1'b0)) u_pwr_sync (
    .clk(aux_clk), .rst_n(rst_n), .d(pwr_req), .q(pwr_s)
  );

  assign rise = pwr_s & ~pwr_d;

  always_ff @(posedge aux_clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_d        <= 1'b0;
      cnt          <= '0;
      ready        <= 1'b0;
      strap_strobe <= 1'b0;
      strap_done   <= 1'b0;
    end else begin
      pwr_d        <= pwr_s;
      strap_strobe <= rise & ~strap_done;
      strap_done   <= strap_done | rise;
      if (!pwr_s)              cnt <= '0;
      else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      ready <= pwr_s && (cnt == CNT_MAX);
    end
  end

  AST_STROBE_PULSE: assert property (@(posedge aux_clk) disable iff (!rst_n)
    strap_strobe |=> !strap_strobe); // R6
  AST_STROBE_ONCE: assert property (@(posedge aux_clk) disable iff (!rst_n)
    strap_done |=> !strap_strobe); // R6
  AST_READY_NEEDS_PWR: assert property (@(posedge aux_clk) disable iff (!rst_n)
    !pwr_s |=> !ready); // R5
endmodule

// File: rtl/out_lane.sv
module out_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic ready_i,
  input  logic reg_en_i,
  input  logic pin_dis_i,
  output logic clk_p_o,
  output logic clk_n_o
);
  logic want;
  logic gate_p;
  logic gate_n;

  assign want = ready_i & reg_en_i & ~pin_dis_i;

  // True-leg gate moves while the clock is low.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) gate_p <= 1'b0;
    else        gate_p <= want;
  end

  // Complement-leg gate moves while the clock is high, trailing the true leg.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_n <= 1'b0;
    else        gate_n <= gate_p;
  end

  assign clk_p_o = clk & gate_p;
  assign clk_n_o = ~clk & gate_n;

  AST_REG_OFF_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_en_i |-> !gate_p); // R4
  AST_PIN_OFF_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    pin_dis_i |-> !gate_p); // R3
  AST_PD_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_i |-> !gate_p); // R5
endmodule

// File: rtl/clk_fanout_gate.sv
module clk_fanout_gate #(
  parameter int unsigned NUM_OUT     = gate_pkg::DEF_NUM_OUT,
  parameter int unsigned WAKE_CYCLES = gate_pkg::DEF_WAKE_CYCLES,
  parameter int unsigned SYNC_STAGES = gate_pkg::DEF_SYNC_STAGES
) (
  input  logic               ref_clk,
  input  logic               aux_clk,
  input  logic               rst_n,
  input  logic               pwr_req,
  input  logic [NUM_OUT-1:0] oe_n,
  input  logic               cfg_we,
  input  logic [NUM_OUT-1:0] cfg_wdata,
  output logic [NUM_OUT-1:0] clk_out_p,
  output logic [NUM_OUT-1:0] clk_out_n,
  output logic               strap_strobe,
  output logic               strap_done
);
  logic               ready_aux;
  logic               ready_ref;
  logic [NUM_OUT-1:0] pin_dis;
  logic [NUM_OUT-1:0] en_reg;

  pwr_sequencer #(.WAKE_CYCLES(WAKE_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_seq (
    .aux_clk(aux_clk), .rst_n(rst_n), .pwr_req(pwr_req),
    .ready(ready_aux), .strap_strobe(strap_strobe), .strap_done(strap_done)
  );

  cdc_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_V(1'b0)) u_rdy_sync (
    .clk(ref_clk), .rst_n(rst_n), .d(ready_aux), .q(ready_ref)
  );

  // Pins reset to "disabled" so nothing starts before they are sampled.
  cdc_sync #(.W(NUM_OUT), .STAGES(SYNC_STAGES), .RST_V(1'b1)) u_pin_sync (
    .clk(ref_clk), .rst_n(rst_n), .d(oe_n), .q(pin_dis)
  );

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)      en_reg <= '1;
    else if (cfg_we) en_reg <= cfg_wdata;
  end

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_lane
    out_lane u_lane (
      .clk(ref_clk), .rst_n(rst_n), .ready_i(ready_ref),
      .reg_en_i(en_reg[i]), .pin_dis_i(pin_dis[i]),
      .clk_p_o(clk_out_p[i]), .clk_n_o(clk_out_n[i])
    );
  end
endmodule

// File: tb/tb_clk_fanout_gate.sv
`timescale 1ns/1ps
module tb_clk_fanout_gate;
  localparam int N    = 7;
  localparam int WAKE = 20;

  logic ref_clk = 1'b0;
  logic aux_clk = 1'b0;
  logic rst_n;
  logic pwr_req;
  logic [N-1:0] oe_n;
  logic cfg_we;
  logic [N-1:0] cfg_wdata;
  logic [N-1:0] clk_out_p, clk_out_n;
  logic strap_strobe, strap_done;

  int checks = 0;
  int failures = 0;
  int strobe_cnt = 0;
  int runt_err = 0;
  bit mon_on = 1'b0;

  clk_fanout_gate #(.NUM_OUT(N), .WAKE_CYCLES(WAKE)) dut (
    .ref_clk(ref_clk), .aux_clk(aux_clk), .rst_n(rst_n), .pwr_req(pwr_req),
    .oe_n(oe_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .clk_out_p(clk_out_p), .clk_out_n(clk_out_n),
    .strap_strobe(strap_strobe), .strap_done(strap_done)
  );

  always #2 ref_clk = ~ref_clk;
  initial begin
    #1.3;
    forever #5 aux_clk = ~aux_clk;
  end

  always @(negedge aux_clk) if (strap_strobe === 1'b1) strobe_cnt++;

  // R9 runt monitor: each leg must hold its value across its whole active phase.
  always @(posedge ref_clk) begin
    logic [N-1:0] a;
    #0.2; a = clk_out_p;
    #1.6; if (mon_on && a !== clk_out_p) runt_err++;
  end
  always @(negedge ref_clk) begin
    logic [N-1:0] a;
    #0.2; a = clk_out_n;
    #1.6; if (mon_on && a !== clk_out_n) runt_err++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_state(input logic [N-1:0] exp, input string req);
    logic [N-1:0] hp, hn, lp, ln;
    @(posedge ref_clk); #1; hp = clk_out_p; hn = clk_out_n;
    @(negedge ref_clk); #1; lp = clk_out_p; ln = clk_out_n;
    for (int i = 0; i < N; i++) begin
      chk(hp[i] === exp[i] && hn[i] === 1'b0 && lp[i] === 1'b0 && ln[i] === exp[i],
          req, {hp[i], hn[i], lp[i], ln[i]}, {exp[i], 1'b0, 1'b0, exp[i]});
    end
  endtask

  task automatic write_cfg(input logic [N-1:0] v);
    @(posedge ref_clk); #1; cfg_we = 1'b1; cfg_wdata = v;
    @(posedge ref_clk); #1; cfg_we = 1'b0;
  endtask

  initial begin
    #600000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    time t0;
    rst_n = 1'b0; pwr_req = 1'b0; oe_n = '0; cfg_we = 1'b0; cfg_wdata = '0;
    #21;
    check_state('0, "R1 in reset");
    chk(strap_strobe === 1'b0 && strap_done === 1'b0, "R1 strap flags in reset",
        {strap_strobe, strap_done}, 0);
    #2.7; rst_n = 1'b1;
    mon_on = 1'b1;
    repeat (20) @(posedge ref_clk);
    check_state('0, "R1 before first power rise");

    // First power-up: R6 strobe and R7 wake window; register defaults all 1 (R1).
    #0.9; pwr_req = 1'b1; t0 = $time;
    #(WAKE * 10 - 8);
    check_state('0, "R7 stopped during wake window");
    #(t0 + (WAKE + 6) * 10 - $time);
    check_state('1, "R1 R2 running with default register");
    chk(strobe_cnt == 1, "R6 single strobe", strobe_cnt, 1);
    chk(strap_done === 1'b1, "R6 done flag", strap_done, 1);

    // R2/R3/R4 sweep: every pin pattern under sixteen register patterns.
    for (int r = 0; r < 16; r++) begin
      logic [N-1:0] rv;
      rv = (r == 0) ? '1 : (r == 1) ? '0 : N'((r * 37 + 5) % 128);
      write_cfg(rv);
      for (int p = 0; p < 128; p++) begin
        @(posedge ref_clk); #1; oe_n = N'(p);
        repeat (4) @(posedge ref_clk);
        check_state(rv & ~N'(p), "R2 R3 R4 sweep");
      end
    end

    // R8 pin latency on lane 2.
    write_cfg('1);
    @(posedge ref_clk); #1; oe_n = '1;
    repeat (5) @(posedge ref_clk);
    #1; oe_n[2] = 1'b0;
    @(posedge ref_clk); #1; chk(clk_out_p[2] === 1'b0, "R8 pin start edge1", clk_out_p[2], 0);
    @(posedge ref_clk); #1; chk(clk_out_p[2] === 1'b0, "R8 pin start edge2", clk_out_p[2], 0);
    @(posedge ref_clk); #1; chk(clk_out_p[2] === 1'b1, "R8 pin start edge3", clk_out_p[2], 1);
    oe_n[2] = 1'b1;
    @(posedge ref_clk); #1; chk(clk_out_p[2] === 1'b1, "R8 pin stop edge1", clk_out_p[2], 1);
    @(posedge ref_clk); #1; chk(clk_out_p[2] === 1'b1, "R8 pin stop edge2", clk_out_p[2], 1);
    @(posedge ref_clk); #1; chk(clk_out_p[2] === 1'b0, "R8 pin stop edge3", clk_out_p[2], 0);

    // R8 register latency on lane 3.
    oe_n = '0;
    repeat (5) @(posedge ref_clk);
    write_cfg(7'b111_0111);
    chk(clk_out_p[3] === 1'b1, "R8 reg stop accept cycle", clk_out_p[3], 1);
    @(posedge ref_clk); #1; chk(clk_out_p[3] === 1'b0, "R8 reg stop next edge", clk_out_p[3], 0);
    write_cfg('1);
    chk(clk_out_p[3] === 1'b0, "R8 reg start accept cycle", clk_out_p[3], 0);
    @(posedge ref_clk); #1; chk(clk_out_p[3] === 1'b1, "R8 reg start next edge", clk_out_p[3], 1);

    // R5 power-down, with enables asking to run.
    #0.4; pwr_req = 1'b0;
    #60;
    check_state('0, "R5 power-down stops all");
    repeat (30) @(posedge ref_clk);
    check_state('0, "R5 held while power low");

    // Second power-up: no strobe (R6), wake window again (R7).
    #0.9; pwr_req = 1'b1; t0 = $time;
    #(WAKE * 10 - 8);
    check_state('0, "R7 stopped during second wake");
    #(t0 + (WAKE + 6) * 10 - $time);
    check_state('1, "R7 running after second wake");
    chk(strobe_cnt == 1, "R6 no strobe on later rise", strobe_cnt, 1);
    chk(strap_done === 1'b1, "R6 done flag kept", strap_done, 1);

    chk(runt_err == 0, "R9 no runt pulses", runt_err, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule